// File: doc/BRIEF.md
# Cascaded Dual-Clock FIFO Slice Ring

The block is a first-in first-out buffer split across a ring of identical slices. Each slice is a small dual-clock FIFO with its own storage, Gray-coded pointers and two-flop synchronizers between the write clock and the read clock. Several slices act as one deep buffer by handing a write token and a read token around the ring. Only the slice holding the write token accepts words, and only the slice holding the read token supplies them. One slice has its first-load strap tied low. After reset that slice holds both tokens, and every other slice has the strap tied high.

A slice that stores a word into its last location passes the write token to the next slice in the same write-clock cycle. The read token moves the same way on the read clock when a slice hands out the word in its last location. Because every slice fills and drains in whole laps, the word order seen at the read port is the same as the order at the write port. The top module builds a ring of slices and combines the per-slice empty, full, almost-empty and almost-full flags with a logical OR. All flags are active high, so each composite flag means "some slice asserts it". The almost flags are only an approximation of the total fill level.

Both data edges use valid/ready handshakes. A word moves on a write-clock edge when `wr_valid` and `wr_ready` are both high. A word leaves on a read-clock edge when `rd_valid` and `rd_ready` are both high. `wr_ready` falls only while the slice holding the write token is full, and a word offered during that time is not taken. Once `rd_valid` is high, it stays high and `rd_data` holds its value until the word is taken. The source may drop `wr_valid`, and the sink may drop `rd_ready`, at any time. Each slice is 18 bits wide, and its depth is a power of two intended to lie between 64 and 4096 words.

Top module: `cfifo_cascade`

## Requirements
- R1: After reset, `wr_ready`=1, `rd_valid`=0, `flag_empty`=1, `flag_almost_empty`=1, `flag_full`=0 and `flag_almost_full`=0.
- R2: Words leave the read port in exactly the order they were accepted at the write port. This holds across slice boundaries and across any number of laps around the ring.
- R3: Starting from reset, accepted words fill slice 0 with DEPTH words, then slice 1, and so on. The write token moves only on a write that lands in the holder's last location.
- R4: Reads drain slice 0 first, then slice 1, and so on, DEPTH words per slice. The read token moves only when the word in the holder's last location is taken.
- R5: `wr_ready` is 0 exactly while the slice holding the write token is full. A word offered while `wr_ready` is 0 is not stored.
- R6: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` stays 1 and `rd_data` stays unchanged on the next read-clock edge.
- R7: Once the pointers have settled, `flag_empty` is 1 if and only if at least one slice holds zero words.
- R8: Once the pointers have settled, `flag_full` is 1 if and only if at least one slice holds DEPTH words.
- R9: Once the pointers have settled, `flag_almost_empty` is 1 if and only if at least one slice holds AE_LEVEL words or fewer.
- R10: Once the pointers have settled, `flag_almost_full` is 1 if and only if at least one slice holds DEPTH-AF_LEVEL words or more.
- R11: Exactly one slice holds the write token and exactly one slice holds the read token at every clock edge outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | A write word is offered |
| wr_ready | output | 1 | The slice holding the write token has room |
| wr_data | input | DATA_W | Write word |
| rd_valid | output | 1 | The slice holding the read token has a word |
| rd_ready | input | 1 | The sink takes the word on this edge |
| rd_data | output | DATA_W | Word at the head of the slice holding the read token |
| flag_empty | output | 1 | Some slice is empty |
| flag_full | output | 1 | Some slice is full |
| flag_almost_empty | output | 1 | Some slice holds AE_LEVEL words or fewer |
| flag_almost_full | output | 1 | Some slice holds DEPTH-AF_LEVEL words or more |

## Verification
A token left behind or passed early makes slices fill and drain out of step. The read port then returns words out of order, or a whole lap of words goes missing, as soon as the reader crosses that slice boundary. This shows within DEPTH words of the fault. A bad pointer or synchronizer makes one composite flag disagree with the per-slice occupancy that the bench computes arithmetically. The bench checks the flags a few read-clock cycles after every single-word step, so such a fault shows at the first step where a slice reaches 0, AE_LEVEL, DEPTH-AF_LEVEL or DEPTH words. A broken full check shows up as a word written over unread data, or as an extra word at the read port.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

  // Per-slice status, all active high.
  typedef struct packed {
    logic empty;
    logic full;
    logic almost_empty;
    logic almost_full;
  } cfifo_flags_t;

endpackage

// File: rtl/cfifo_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
module cfifo_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cfifo_gray2bin.sv
// Gray to binary: each bit is the XOR of all bits at and above it.
module cfifo_gray2bin #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] gray,
  output logic [WIDTH-1:0] bin
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bin[i] = ^gray[WIDTH-1:i];
  end
endmodule

// File: rtl/cfifo_slice.sv
// One slice: dual-clock storage with write and read token ownership.
module cfifo_slice
  import cfifo_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int DATA_W   = 18,
  parameter int AE_LEVEL = 4,
  parameter int AF_LEVEL = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              first_load_n,
  // write domain
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_xi,
  output logic              wr_xo,
  output logic              wr_open,
  output logic              wr_tok,
  // read domain
  input  logic              rd_req,
  input  logic              rd_xi,
  output logic              rd_xo,
  output logic              rd_open,
  output logic              rd_tok,
  output logic [DATA_W-1:0] rd_data,
  output cfifo_flags_t      flags
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [PW-1:0] AE_LIM = PW'(AE_LEVEL);
  localparam logic [PW-1:0] AF_LIM = PW'(DEPTH - AF_LEVEL);

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rgray_w, rbin_w, wocc;
  logic          push, full_w;

  cfifo_sync #(.WIDTH(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
  );
  cfifo_gray2bin #(.WIDTH(PW)) u_rconv (.gray(rgray_w), .bin(rbin_w));

  assign full_w  = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign wocc    = wbin - rbin_w;
  assign wr_open = wr_tok & ~full_w;
  assign push    = wr_req & wr_open;
  assign wr_xo   = push & (wbin[AW-1:0] == LAST);

  always_ff @(posedge wr_clk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      wr_tok <= ~first_load_n;
    end else begin
      if (push) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
      if (wr_xi)      wr_tok <= 1'b1;
      else if (wr_xo) wr_tok <= 1'b0;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, wgray_r, wbin_r, rocc;
  logic          pop, empty_r;

  cfifo_sync #(.WIDTH(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
  );
  cfifo_gray2bin #(.WIDTH(PW)) u_wconv (.gray(wgray_r), .bin(wbin_r));

  assign empty_r = (rgray == wgray_r);
  assign rocc    = wbin_r - rbin;
  assign rd_open = rd_tok & ~empty_r;
  assign pop     = rd_req & rd_open;
  assign rd_xo   = pop & (rbin[AW-1:0] == LAST);
  assign rd_data = mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      rd_tok <= ~first_load_n;
    end else begin
      if (pop) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
      if (rd_xi)      rd_tok <= 1'b1;
      else if (rd_xo) rd_tok <= 1'b0;
    end
  end

  assign flags.empty        = empty_r;
  assign flags.full         = full_w;
  assign flags.almost_empty = (rocc <= AE_LIM);
  assign flags.almost_full  = (wocc >= AF_LIM);
endmodule

// File: rtl/cfifo_cascade.sv
// Ring of FIFO slices with composite flags.
module cfifo_cascade
  import cfifo_pkg::*;
#(
  parameter int NUM_SLICES = 3,
  parameter int DEPTH      = 64,
  parameter int DATA_W     = 18,
  parameter int AE_LEVEL   = 4,
  parameter int AF_LEVEL   = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_empty,
  output logic              flag_full,
  output logic              flag_almost_empty,
  output logic              flag_almost_full
);
  logic [NUM_SLICES-1:0] wr_xo_v, rd_xo_v, wr_open_v, rd_open_v;
  logic [NUM_SLICES-1:0] wr_tok_v, rd_tok_v;
  logic [DATA_W-1:0]     sl_data  [NUM_SLICES];
  cfifo_flags_t          sl_flags [NUM_SLICES];

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    localparam int PREV = (s + NUM_SLICES - 1) % NUM_SLICES;
    cfifo_slice #(
      .DEPTH(DEPTH), .DATA_W(DATA_W),
      .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)
    ) u_slice (
      .wr_clk      (wr_clk),
      .rd_clk      (rd_clk),
      .rst_n       (rst_n),
      .first_load_n((s == 0) ? 1'b0 : 1'b1),
      .wr_req      (wr_valid),
      .wr_data     (wr_data),
      .wr_xi       (wr_xo_v[PREV]),
      .wr_xo       (wr_xo_v[s]),
      .wr_open     (wr_open_v[s]),
      .wr_tok      (wr_tok_v[s]),
      .rd_req      (rd_ready),
      .rd_xi       (rd_xo_v[PREV]),
      .rd_xo       (rd_xo_v[s]),
      .rd_open     (rd_open_v[s]),
      .rd_tok      (rd_tok_v[s]),
      .rd_data     (sl_data[s]),
      .flags       (sl_flags[s])
    );
  end

  assign wr_ready = |wr_open_v;
  assign rd_valid = |rd_open_v;

  always_comb begin
    rd_data           = '0;
    flag_empty        = 1'b0;
    flag_full         = 1'b0;
    flag_almost_empty = 1'b0;
    flag_almost_full  = 1'b0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (rd_tok_v[s]) rd_data = rd_data | sl_data[s];
      flag_empty        = flag_empty        | sl_flags[s].empty;
      flag_full         = flag_full         | sl_flags[s].full;
      flag_almost_empty = flag_almost_empty | sl_flags[s].almost_empty;
      flag_almost_full  = flag_almost_full  | sl_flags[s].almost_full;
    end
  end
endmodule

// File: rtl/cfifo_cascade_chk.sv
module cfifo_cascade_chk #(
  parameter int NUM_SLICES = 3,
  parameter int DATA_W     = 18
) (
  input logic                  wr_clk,
  input logic                  rd_clk,
  input logic                  rst_n,
  input logic                  wr_valid,
  input logic                  wr_ready,
  input logic                  rd_valid,
  input logic                  rd_ready,
  input logic [DATA_W-1:0]     rd_data,
  input logic                  flag_empty,
  input logic                  flag_full,
  input logic [NUM_SLICES-1:0] wr_tok_v,
  input logic [NUM_SLICES-1:0] rd_tok_v
);
  AST_WR_TOKEN_SINGLE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_tok_v) == 1); // R11
  AST_RD_TOKEN_SINGLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_tok_v) == 1); // R11
  AST_WR_TOKEN_STILL: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(wr_tok_v)); // R3
  AST_RD_TOKEN_STILL: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> $stable(rd_tok_v)); // R4
  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R6
  AST_EMPTY_COMPOSITE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_valid |-> flag_empty); // R7
  AST_FULL_COMPOSITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |-> flag_full); // R8
endmodule

bind cfifo_cascade cfifo_cascade_chk #(
  .NUM_SLICES(NUM_SLICES), .DATA_W(DATA_W)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .flag_empty(flag_empty), .flag_full(flag_full),
  .wr_tok_v(wr_tok_v), .rd_tok_v(rd_tok_v)
);

// File: tb/cfifo_cascade_bench.sv
module cfifo_cascade_bench;
  localparam int WR_HALF = 5;
  localparam int RD_HALF = 7;
  localparam int NS  = 3;
  localparam int D   = 8;
  localparam int DW  = 18;
  localparam int AE  = 2;
  localparam int AF  = 2;
  localparam int CAP = NS * D;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic f_empty, f_full, f_ae, f_af;

  int errors = 0;
  int checks = 0;

  always #(WR_HALF) wr_clk = ~wr_clk;
  always #(RD_HALF) rd_clk = ~rd_clk;

  cfifo_cascade #(
    .NUM_SLICES(NS), .DEPTH(D), .DATA_W(DW), .AE_LEVEL(AE), .AF_LEVEL(AF)
  ) u_cfifo_cascade (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .flag_empty(f_empty), .flag_full(f_full),
    .flag_almost_empty(f_ae), .flag_almost_full(f_af)
  );

  function automatic logic [DW-1:0] pat(int k, int base);
    return DW'((k * 1031 + base * 97 + 5) % 262144);
  endfunction

  function automatic int clampd(int v);
    return (v < 0) ? 0 : ((v > D) ? D : v);
  endfunction

  // occupancy of slice i after w writes and r reads from reset (no lap)
  function automatic int occ(int i, int w, int r);
    return clampd(w - i * D) - clampd(r - i * D);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic push(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge wr_clk);
    @(posedge wr_clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge rd_clk);
    d = rd_data;
    @(posedge rd_clk);
    #1 rd_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic check_flags(string ctx, int w, int r);
    int e = 0, f = 0, ae = 0, af = 0;
    for (int i = 0; i < NS; i++) begin
      int o = occ(i, w, r);
      if (o == 0) e = 1;
      if (o == D) f = 1;
      if (o <= AE) ae = 1;
      if (o >= D - AF) af = 1;
    end
    check($sformatf("R7 empty %s w=%0d r=%0d", ctx, w, r), int'(f_empty), e);
    check($sformatf("R8 full %s w=%0d r=%0d", ctx, w, r), int'(f_full), f);
    check($sformatf("R9 almost_empty %s w=%0d r=%0d", ctx, w, r), int'(f_ae), ae);
    check($sformatf("R10 almost_full %s w=%0d r=%0d", ctx, w, r), int'(f_af), af);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;

    // R1: reset state
    do_reset();
    check("R1 wr_ready", int'(wr_ready), 1);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 flag_empty", int'(f_empty), 1);
    check("R1 flag_almost_empty", int'(f_ae), 1);
    check("R1 flag_full", int'(f_full), 0);
    check("R1 flag_almost_full", int'(f_af), 0);

    // R3/R7..R10: fill sweep over every fill level, then ordered drain (R2, R4)
    for (int w = 0; w <= CAP; w++) begin
      do_reset();
      for (int k = 0; k < w; k++) push(pat(k, w));
      settle();
      check_flags("fill R3", w, 0);
      check($sformatf("R5 wr_ready after %0d writes", w), int'(wr_ready), (w < CAP) ? 1 : 0);
      check($sformatf("R3 rd_valid after %0d writes", w), int'(rd_valid), (w > 0) ? 1 : 0);
      for (int k = 0; k < w; k++) begin
        pop(got);
        check($sformatf("R2 R4 order w=%0d k=%0d", w, k), int'(got), int'(pat(k, w)));
      end
      settle();
      check($sformatf("R4 rd_valid after drain w=%0d", w), int'(rd_valid), 0);
    end

    // R4/R7..R10: drain sweep from full, one word at a time
    do_reset();
    for (int k = 0; k < CAP; k++) push(pat(k, 77));
    for (int r = 1; r <= CAP; r++) begin
      pop(got);
      check($sformatf("R4 drain data r=%0d", r), int'(got), int'(pat(r - 1, 77)));
      settle();
      check_flags("drain R4", CAP, r);
      check($sformatf("R5 wr_ready r=%0d", r), int'(wr_ready), 1);
    end

    // R5: a word offered while wr_ready is low is not stored
    do_reset();
    for (int k = 0; k < CAP; k++) push(pat(k, 5));
    settle();
    @(negedge wr_clk);
    wr_valid = 1'b1; wr_data = 18'h2AAAA;
    repeat (6) @(negedge wr_clk);
    check("R5 wr_ready held low when holder full", int'(wr_ready), 0);
    wr_valid = 1'b0;
    for (int k = 0; k < CAP; k++) begin
      pop(got);
      check($sformatf("R5 R2 data after rejected offer k=%0d", k), int'(got), int'(pat(k, 5)));
    end
    settle();
    check("R5 rejected word absent", int'(rd_valid), 0);

    // R6: output holds under read back-pressure
    do_reset();
    for (int k = 0; k < 3; k++) push(pat(k, 9));
    settle();
    for (int c = 0; c < 5; c++) begin
      @(negedge rd_clk);
      check($sformatf("R6 rd_valid hold c=%0d", c), int'(rd_valid), 1);
      check($sformatf("R6 rd_data hold c=%0d", c), int'(rd_data), int'(pat(0, 9)));
    end
    for (int k = 0; k < 3; k++) pop(got);

    // R2/R11: concurrent streaming over several laps of the ring
    do_reset();
    fork
      begin
        for (int k = 0; k < 300; k++) begin
          push(pat(k, 3));
          if (k % 7 == 3) repeat (3) @(negedge wr_clk);
          if ((k / 40) % 2 == 1) repeat (2) @(negedge wr_clk);
        end
      end
      begin
        for (int k = 0; k < 300; k++) begin
          logic [DW-1:0] g;
          pop(g);
          check($sformatf("R2 R11 stream k=%0d", k), int'(g), int'(pat(k, 3)));
          if (k % 5 == 1) repeat (4) @(negedge rd_clk);
        end
      end
    join
    settle();
    check("R11 stream ends empty", int'(rd_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule